// File: doc/BRIEF.md
# UART Modem Handshake and Interrupt Controller

This block holds the modem handshake state and the interrupt state of a 16550-style serial port. A control register drives four modem outputs (data terminal ready, request to send and two general-purpose lines). The four modem inputs (clear to send, data set ready, ring, carrier detect) pass through a two-flop synchronizer. Their changes are recorded as sticky delta bits, which a status read returns and then clears. A loopback bit turns the port back on itself. The modem outputs then stand in for the modem inputs, the serial output pin is held idle-high, and the transmitter's bit stream goes straight to the receiver's input.

The receive, transmit and line-status paths report events through single-cycle pulses. Each event latches a pending flag, and the flag is cleared by the register access that services it. Four enable bits gate the three latched sources and the modem-status source onto a single registered interrupt line. An identification register shows every enabled pending source as a separate bit, with no priority encoding.

Host access uses a synchronous strobe interface. A write takes effect on the clock edge where `reg_wr` is high. A read returns its value in `reg_rdata` on the edge after `reg_rd` was high, and any clear caused by that read happens on the same edge.

Top module: `uart_modem_irq`

## Requirements
- R1: After synchronous reset, with all modem pins low, the following hold: `irq`, `reg_rdata` and all four modem outputs are 0; `sout` and `rx_line_out` are 1; a read of offset 6 returns 0x00; a read of offset 2 with `fifo_en` low returns 0x00.
- R2: A write to offset 4 stores bits 4:0. From the next cycle, bit 0 drives `dtr_out`, bit 1 `rts_out`, bit 2 `aux1_out` and bit 3 `aux2_out`. A read of offset 4 returns the five stored bits with bits 7:5 zero.
- R3: A read of offset 6 returns the synchronized live levels in bits 7:4, in the order bit 4 CTS, bit 5 DSR, bit 6 RI, bit 7 DCD.
- R4: Delta bits 0, 1 and 3 of offset 6 latch on any change of CTS, DSR and DCD respectively. Delta bit 2 latches only on a 0-to-1 change of RI. All four stay set until a status read.
- R5: A read of offset 6 returns the deltas accumulated so far and clears them. A change in the same cycle as the read is kept.
- R6: When offset-4 bit 4 is set (loopback), the effective inputs become DSR = bit 0, CTS = bit 1, RI = bit 2 and DCD = bit 3. Activity on the four modem input pins then changes neither the levels nor the deltas.
- R7: In loopback, `sout` is 1 and `rx_line_out` follows `tx_line_in` one cycle later. Outside loopback, `sout` follows `tx_line_in` and `rx_line_out` follows `sin`, each one cycle later.
- R8: A write to offset 1 stores the enables: bit 0 received data, bit 1 transmit empty, bit 2 line status, bit 3 modem status. A read of offset 1 returns them in bits 3:0.
- R9: A read of offset 2 returns one bit per enabled pending source: bit 0 line status, bit 1 received data, bit 2 transmit empty, bit 3 modem status (any delta set). Bits 5:4 read 0. Bits 7:6 both equal `fifo_en`.
- R10: Line-status pending clears on a read of offset 5. Received-data pending clears on a read of offset 0. Transmit-empty pending clears on a read of offset 2 or a write to offset 0. Modem pending clears on a read of offset 6.
- R11: `irq` is the OR of all enabled pending sources, registered one cycle after the pending state. It is 0 whenever all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| fifo_en | input | 1 | FIFO mode flag from the FIFO control logic |
| rx_avail_set | input | 1 | Pulse: received data available |
| tx_empty_set | input | 1 | Pulse: transmit buffer empty |
| line_err_set | input | 1 | Pulse: receiver line status event |
| tx_line_in | input | 1 | Serial bit stream from the transmitter |
| rx_line_out | output | 1 | Serial bit stream to the receiver |
| sout | output | 1 | Serial output pin |
| sin | input | 1 | Serial input pin |
| cts_in | input | 1 | Clear-to-send pin |
| dsr_in | input | 1 | Data-set-ready pin |
| ri_in | input | 1 | Ring pin |
| dcd_in | input | 1 | Carrier-detect pin |
| dtr_out | output | 1 | Data-terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| aux1_out | output | 1 | General-purpose output 1 |
| aux2_out | output | 1 | General-purpose output 2 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default two-stage synchronizer and its fixed set of four modem lines. This configuration is small enough to cover every pair of old and new modem-pin levels (256 transitions), all 16 control-register values with and without loopback, and all 16 enable masks against each of the four interrupt sources. Covering every pin pair checks the rising-edge-only ring delta against the any-change deltas on every combination. Covering every enable mask checks the remapping between the enable bit order and the identification bit order, as well as each source's own clear access.

// File: rtl/uart_mi_pkg.sv
package uart_mi_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NUM_LINES = 4;

  localparam logic [ADDR_W-1:0] ADR_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_IID   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_MSTAT = 3'd6;

  // modem line positions inside the input vector and the status nibble
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  // modem control field positions
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_AUX1 = 2;
  localparam int MC_AUX2 = 3;
  localparam int MC_LOOP = 4;
  localparam int MC_W    = 5;

  // interrupt source positions in the identification byte
  localparam int SRC_LINE = 0;
  localparam int SRC_RX   = 1;
  localparam int SRC_TX   = 2;
  localparam int SRC_MDM  = 3;
  localparam int NUM_SRC  = 4;
  localparam int NUM_STICKY = 3;

  // enable bit positions
  localparam int EN_RX   = 0;
  localparam int EN_TX   = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;
endpackage

// File: rtl/uart_mi_sync.sv
module uart_mi_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/uart_mi_modem.sv
module uart_mi_modem
  import uart_mi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mctl_wr,
  input  logic [MC_W-1:0]      mctl_wdata,
  input  logic                 mstat_rd,
  input  logic [NUM_LINES-1:0] pins_raw,
  output logic [MC_W-1:0]      mctl_q,
  output logic [2*NUM_LINES-1:0] mstat,
  output logic                 delta_any
);
  logic [NUM_LINES-1:0] pins_sync;
  logic [NUM_LINES-1:0] lb_lines;
  logic [NUM_LINES-1:0] eff;
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] chg;
  logic [NUM_LINES-1:0] delta_set;
  logic [NUM_LINES-1:0] delta_q;
  logic                 loop_en;

  always_ff @(posedge clk) begin
    if (rst) mctl_q <= '0;
    else if (mctl_wr) mctl_q <= mctl_wdata;
  end

  uart_mi_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_sync)
  );

  assign loop_en = mctl_q[MC_LOOP];

  always_comb begin
    lb_lines         = '0;
    lb_lines[LN_DSR] = mctl_q[MC_DTR];
    lb_lines[LN_CTS] = mctl_q[MC_RTS];
    lb_lines[LN_RI]  = mctl_q[MC_AUX1];
    lb_lines[LN_DCD] = mctl_q[MC_AUX2];
  end

  assign eff = loop_en ? lb_lines : pins_sync;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= eff;
  end

  assign chg = eff ^ prev_q;

  always_comb begin
    delta_set        = chg;
    delta_set[LN_RI] = eff[LN_RI] & ~prev_q[LN_RI];
  end

  always_ff @(posedge clk) begin
    if (rst) delta_q <= '0;
    else     delta_q <= (mstat_rd ? '0 : delta_q) | delta_set;
  end

  assign mstat     = {eff, delta_q};
  assign delta_any = |delta_q;

  // R5
  mstat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mstat_rd && (delta_set == '0)) |=> (delta_q == '0));

  // R4
  delta_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !mstat_rd |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  // R4
  ri_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_q[LN_RI] && !eff[LN_RI] && !mstat_rd) |=> (delta_q[LN_RI] == $past(delta_q[LN_RI])));
endmodule

// File: rtl/uart_mi_irq.sv
module uart_mi_irq
  import uart_mi_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ien_wr,
  input  logic [NUM_SRC-1:0]  ien_wdata,
  input  logic                rx_set,
  input  logic                tx_set,
  input  logic                line_set,
  input  logic                rx_clr,
  input  logic                tx_clr,
  input  logic                line_clr,
  input  logic                modem_pend,
  input  logic                fifo_en,
  output logic [NUM_SRC-1:0]  ien_q,
  output logic [DATA_W-1:0]   iid,
  output logic                irq
);
  logic [NUM_STICKY-1:0] set_v;
  logic [NUM_STICKY-1:0] clr_v;
  logic [NUM_STICKY-1:0] pend_q;
  logic [NUM_SRC-1:0]    src_pend;
  logic [NUM_SRC-1:0]    en_by_src;
  logic [NUM_SRC-1:0]    active;

  always_ff @(posedge clk) begin
    if (rst) ien_q <= '0;
    else if (ien_wr) ien_q <= ien_wdata;
  end

  always_comb begin
    set_v           = '0;
    clr_v           = '0;
    set_v[SRC_LINE] = line_set;
    set_v[SRC_RX]   = rx_set;
    set_v[SRC_TX]   = tx_set;
    clr_v[SRC_LINE] = line_clr;
    clr_v[SRC_RX]   = rx_clr;
    clr_v[SRC_TX]   = tx_clr;
  end

  // a new event in the clearing cycle wins, so none is lost
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      for (int i = 0; i < NUM_STICKY; i++) begin
        pend_q[i] <= set_v[i] | (pend_q[i] & ~clr_v[i]);
      end
    end
  end

  assign src_pend = {modem_pend, pend_q};

  always_comb begin
    en_by_src           = '0;
    en_by_src[SRC_LINE] = ien_q[EN_LINE];
    en_by_src[SRC_RX]   = ien_q[EN_RX];
    en_by_src[SRC_TX]   = ien_q[EN_TX];
    en_by_src[SRC_MDM]  = ien_q[EN_MDM];
  end

  assign active = src_pend & en_by_src;
  assign iid    = {fifo_en, fifo_en, {(DATA_W-2-NUM_SRC){1'b0}}, active};

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |active;
  end

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq);

  // R10
  tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_clr && !tx_set) |=> !pend_q[SRC_TX]);

  // R10
  line_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (line_clr && !line_set) |=> !pend_q[SRC_LINE]);
endmodule

// File: rtl/uart_modem_irq.sv
module uart_modem_irq
  import uart_mi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fifo_en,
  input  logic              rx_avail_set,
  input  logic              tx_empty_set,
  input  logic              line_err_set,
  input  logic              tx_line_in,
  output logic              rx_line_out,
  output logic              sout,
  input  logic              sin,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              ri_in,
  input  logic              dcd_in,
  output logic              dtr_out,
  output logic              rts_out,
  output logic              aux1_out,
  output logic              aux2_out,
  output logic              irq
);
  logic                   mctl_wr, ien_wr, mstat_rd;
  logic                   rx_clr, tx_clr, line_clr;
  logic [MC_W-1:0]        mctl_q;
  logic [2*NUM_LINES-1:0] mstat;
  logic                   delta_any;
  logic [NUM_SRC-1:0]     ien_q;
  logic [DATA_W-1:0]      iid;
  logic [NUM_LINES-1:0]   pins_raw;
  logic [DATA_W-1:0]      rd_mux;
  logic                   unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:MC_W];

  assign mctl_wr  = reg_wr && (reg_addr == ADR_MCTL);
  assign ien_wr   = reg_wr && (reg_addr == ADR_IEN);
  assign mstat_rd = reg_rd && (reg_addr == ADR_MSTAT);
  assign rx_clr   = reg_rd && (reg_addr == ADR_DATA);
  assign line_clr = reg_rd && (reg_addr == ADR_LSTAT);
  assign tx_clr   = (reg_rd && (reg_addr == ADR_IID)) || (reg_wr && (reg_addr == ADR_DATA));

  always_comb begin
    pins_raw         = '0;
    pins_raw[LN_CTS] = cts_in;
    pins_raw[LN_DSR] = dsr_in;
    pins_raw[LN_RI]  = ri_in;
    pins_raw[LN_DCD] = dcd_in;
  end

  uart_mi_modem #(.SYNC_STAGES(SYNC_STAGES)) u_modem (
    .clk        (clk),
    .rst        (rst),
    .mctl_wr    (mctl_wr),
    .mctl_wdata (reg_wdata[MC_W-1:0]),
    .mstat_rd   (mstat_rd),
    .pins_raw   (pins_raw),
    .mctl_q     (mctl_q),
    .mstat      (mstat),
    .delta_any  (delta_any)
  );

  uart_mi_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .ien_wr     (ien_wr),
    .ien_wdata  (reg_wdata[NUM_SRC-1:0]),
    .rx_set     (rx_avail_set),
    .tx_set     (tx_empty_set),
    .line_set   (line_err_set),
    .rx_clr     (rx_clr),
    .tx_clr     (tx_clr),
    .line_clr   (line_clr),
    .modem_pend (delta_any),
    .fifo_en    (fifo_en),
    .ien_q      (ien_q),
    .iid        (iid),
    .irq        (irq)
  );

  assign dtr_out  = mctl_q[MC_DTR];
  assign rts_out  = mctl_q[MC_RTS];
  assign aux1_out = mctl_q[MC_AUX1];
  assign aux2_out = mctl_q[MC_AUX2];

  always_comb begin
    unique case (reg_addr)
      ADR_IEN:   rd_mux = {{(DATA_W-NUM_SRC){1'b0}}, ien_q};
      ADR_IID:   rd_mux = iid;
      ADR_MCTL:  rd_mux = {{(DATA_W-MC_W){1'b0}}, mctl_q};
      ADR_MSTAT: rd_mux = mstat;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sout        <= 1'b1;
      rx_line_out <= 1'b1;
    end else begin
      sout        <= mctl_q[MC_LOOP] ? 1'b1 : tx_line_in;
      rx_line_out <= mctl_q[MC_LOOP] ? tx_line_in : sin;
    end
  end

  // R7
  loop_sout_chk: assert property (@(posedge clk) disable iff (rst)
    mctl_q[MC_LOOP] |=> sout);
endmodule

// File: tb/uart_modem_irq_test.sv
module uart_modem_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       fifo_en, rx_avail_set, tx_empty_set, line_err_set;
  logic       tx_line_in, rx_line_out, sout, sin;
  logic       cts_in, dsr_in, ri_in, dcd_in;
  logic       dtr_out, rts_out, aux1_out, aux2_out, irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_modem_irq uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_en(fifo_en),
    .rx_avail_set(rx_avail_set), .tx_empty_set(tx_empty_set), .line_err_set(line_err_set),
    .tx_line_in(tx_line_in), .rx_line_out(rx_line_out), .sout(sout), .sin(sin),
    .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
    .dtr_out(dtr_out), .rts_out(rts_out), .aux1_out(aux1_out), .aux2_out(aux2_out),
    .irq(irq)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // pin vector order: bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD
  task automatic set_pins(input logic [3:0] m);
    @(negedge clk);
    {dcd_in, ri_in, dsr_in, cts_in} = m;
  endtask

  task automatic pulse_src(input int s);
    @(negedge clk);
    case (s)
      0: line_err_set = 1'b1;
      1: rx_avail_set = 1'b1;
      default: tx_empty_set = 1'b1;
    endcase
    @(negedge clk);
    line_err_set = 1'b0; rx_avail_set = 1'b0; tx_empty_set = 1'b0;
  endtask

  logic [7:0] rd;
  logic [3:0] exp_d;
  logic       cts_state;

  initial begin
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    fifo_en = 0; rx_avail_set = 0; tx_empty_set = 0; line_err_set = 0;
    tx_line_in = 1; sin = 1; cts_in = 0; dsr_in = 0; ri_in = 0; dcd_in = 0;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 modem outs", {4'd0, aux2_out, aux1_out, rts_out, dtr_out}, 8'h00);
    check("R1 serial idle", {6'd0, sout, rx_line_out}, 8'h03);
    reg_read(3'd6, rd); check("R1 mstat", rd, 8'h00);
    reg_read(3'd2, rd); check("R1 iid", rd, 8'h00);

    // R2 control register drives outputs, readback
    for (int v = 0; v < 16; v++) begin
      reg_write(3'd4, 8'hE0 | 8'(v));
      check("R2 outputs", {4'd0, aux2_out, aux1_out, rts_out, dtr_out}, 8'(v));
      reg_read(3'd4, rd); check("R2 readback", rd, 8'(v));
    end
    reg_write(3'd4, 8'h00);

    // R3 R4 R5 every old/new pin pair
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < 16; n++) begin
        set_pins(4'(p)); idle(4);
        reg_read(3'd6, rd);
        check("R3 live after settle", {4'd0, rd[7:4]}, 8'(p));
        set_pins(4'(n)); idle(4);
        exp_d = ((4'(p) ^ 4'(n)) & 4'b1011) | (~4'(p) & 4'(n) & 4'b0100);
        reg_read(3'd6, rd);
        check("R4 deltas", rd, {4'(n), exp_d});
        reg_read(3'd6, rd);
        check("R5 cleared by read", rd, {4'(n), 4'h0});
      end
    end
    set_pins(4'h0); idle(4); reg_read(3'd6, rd);

    // R6 loopback crossover, pins ignored
    for (int v = 0; v < 16; v++) begin
      reg_write(3'd4, 8'h10 | 8'(v));
      idle(4); reg_read(3'd6, rd);
      set_pins(~4'(v)); idle(4);
      reg_read(3'd6, rd);
      check("R6 loopback levels", rd, {4'(v >> 3), 4'(v >> 2) & 4'h0, 4'h0, 4'h0} & 8'h00 |
            {(v & 8) != 0, (v & 4) != 0, (v & 1) != 0, (v & 2) != 0, 4'h0});
      set_pins(4'(v)); idle(4);
      reg_read(3'd6, rd);
      check("R6 pins ignored", {4'd0, rd[3:0]}, 8'h00);
    end

    // R7 serial path in loopback
    reg_write(3'd4, 8'h10);
    @(negedge clk); tx_line_in = 0; sin = 1;
    @(negedge clk);
    check("R7 loop sout high", {7'd0, sout}, 8'h01);
    check("R7 loop rx from tx 0", {7'd0, rx_line_out}, 8'h00);
    tx_line_in = 1; sin = 0;
    @(negedge clk);
    check("R7 loop rx from tx 1", {7'd0, rx_line_out}, 8'h01);
    check("R7 loop sout still high", {7'd0, sout}, 8'h01);
    reg_write(3'd4, 8'h00);
    @(negedge clk); tx_line_in = 0; sin = 1;
    @(negedge clk);
    check("R7 normal sout", {7'd0, sout}, 8'h00);
    check("R7 normal rx", {7'd0, rx_line_out}, 8'h01);
    tx_line_in = 1; sin = 0;
    @(negedge clk);
    check("R7 normal sout 1", {7'd0, sout}, 8'h01);
    check("R7 normal rx 0", {7'd0, rx_line_out}, 8'h00);
    sin = 1;
    set_pins(4'h0); idle(4); reg_read(3'd6, rd);
    cts_state = 1'b0;

    // R8 R9 R10 R11 every enable mask against every source
    for (int e = 0; e < 16; e++) begin
      reg_write(3'd1, 8'hF0 | 8'(e));
      reg_read(3'd1, rd); check("R8 enable readback", rd, 8'(e));
      for (int s = 0; s < 4; s++) begin
        logic en;
        case (s)
          0: en = e[2];
          1: en = e[0];
          2: en = e[1];
          default: en = e[3];
        endcase
        if (s < 3) begin
          pulse_src(s); idle(2);
        end else begin
          cts_state = ~cts_state;
          set_pins({3'b000, cts_state}); idle(5);
        end
        check("R11 irq follows enabled source", {7'd0, irq}, {7'd0, en});
        reg_read(3'd2, rd);
        check("R9 id bit", rd, en ? 8'(1 << s) : 8'h00);
        case (s)
          0: reg_read(3'd5, rd);
          1: reg_read(3'd0, rd);
          3: reg_read(3'd6, rd);
          default: ;
        endcase
        idle(2);
        check("R10 irq after clear", {7'd0, irq}, 8'h00);
        reg_read(3'd2, rd);
        check("R10 id after clear", rd, 8'h00);
      end
    end

    // R10 transmit pending cleared by data write
    reg_write(3'd1, 8'h0F);
    pulse_src(2); idle(2);
    check("R10 tx pending irq", {7'd0, irq}, 8'h01);
    reg_write(3'd0, 8'h5A); idle(2);
    check("R10 tx cleared by data write", {7'd0, irq}, 8'h00);

    // R9 R11 several sources, FIFO flag
    pulse_src(0); pulse_src(1); pulse_src(2); idle(2);
    reg_read(3'd2, rd); check("R9 all three", rd, 8'h07);
    reg_read(3'd2, rd); check("R10 tx gone after id read", rd, 8'h03);
    fifo_en = 1'b1;
    reg_read(3'd2, rd); check("R9 fifo flag", rd, 8'hC3);
    reg_read(3'd5, rd); idle(2);
    check("R11 still pending rx", {7'd0, irq}, 8'h01);
    reg_read(3'd2, rd); check("R10 line cleared", rd, 8'hC2);
    reg_read(3'd0, rd); idle(2);
    check("R11 all cleared", {7'd0, irq}, 8'h00);
    reg_write(3'd1, 8'h00);
    pulse_src(1); idle(2);
    check("R11 masked source", {7'd0, irq}, 8'h00);
    reg_read(3'd2, rd); check("R9 masked id", rd, 8'hC0);

    finish_run();
  end
endmodule